// File: doc/BRIEF.md
# USB Host Controller Control and Status Register Block

This block sits next to a USB host controller and gives software a small memory-mapped window onto the controller's static configuration pins and its error interrupt. A plain 32-bit register bus (write strobe, byte address, write data, combinational read data) reaches eight control registers. Each register drives its raw value straight onto an output port: bus-filter bypass, port straps, frame-length adjust, endianness select, coherency select, bus-master enable, error-response enable, and one general 32-bit scratch word.

The interrupt side has two sources: a host system error and an address decode error. A one-cycle pulse on either error input latches a status bit. Software clears a status bit by writing 1 to it. The mask cannot be written directly. Software clears mask bits through a write-only enable register and sets them through a write-only disable register. One level-sensitive interrupt output is high while any unmasked status bit is set.

Only aligned 32-bit accesses are decoded. Any other address, including a misaligned one, reads as zero and absorbs writes.

Top module: `usb_ctl_csr`

## Requirements
- R1: After reset, frame-length adjust (0x38) reads 0x20, bus-master enable (0x48) reads 1, interrupt mask (0x68) reads 0x3 and every other register reads 0. The interrupt output is low.
- R2: Control registers keep only their field bits: 0x30 bits 3:0, 0x34 bits 4:0, 0x38 bits 5:0, and bit 0 at 0x40, 0x44, 0x48 and 0x60. Bits above a field read 0 and ignore writes. Each output port equals its register value.
- R3: The register at 0x78 stores and returns all 32 bits, which appear on its output port.
- R4: Reads of any address other than the twelve mapped word addresses (0x30, 0x34, 0x38, 0x40, 0x44, 0x48, 0x60, 0x64, 0x68, 0x6C, 0x70, 0x78) return 0. This includes addresses whose low two bits are not 00. Writes to those addresses change no register.
- R5: Interrupt status lives at 0x64. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: A pulse on an error input sets its status bit on the next edge. If a write-one-to-clear of that bit happens in the same cycle, the bit stays set.
- R7: Mask (0x68) ignores writes. Writing enable (0x6C) clears the mask bits where the data has ones. Writing disable (0x70) sets them. Enable and disable always read 0.
- R8: The interrupt output equals OR over bits of (status AND NOT mask). It is updated one cycle after the event or write that changes either.
- R9: Bit 1 of status, mask, enable and disable belongs to the host system error input. Bit 0 belongs to the address decode error input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (7) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| err_host_sys | input | 1 | Host system error pulse |
| err_addr_dec | input | 1 | Address decode error pulse |
| irq_out | output | 1 | Level interrupt |
| filt_bypass_o | output | 4 | Bus-filter bypass controls |
| port_ctl_o | output | 5 | Port strap controls |
| fladj_o | output | 6 | Frame-length adjust |
| big_endian_o | output | 1 | Endianness select |
| coherent_o | output | 1 | Coherency select |
| bm_enable_o | output | 1 | Bus-master enable |
| slv_err_en_o | output | 1 | Error-response enable |
| spare_o | output | DW (32) | Scratch register value |

## Verification
An error pulse and a software write-one-to-clear of the same status bit can fall in the same clock cycle. The bench creates this collision by raising the host-error input in the cycle in which it writes 0x3 to status. It then expects status to read 0x2 afterwards: the colliding bit stays set and the other bit clears. The bench also sweeps all sixteen combinations of status pattern and enable pattern and checks that the interrupt output follows each one. It does the same for every unmapped and misaligned address.

// File: rtl/usb_ctl_csr.sv
module usb_ctl_csr #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          err_host_sys,
  input  logic          err_addr_dec,
  output logic          irq_out,
  output logic [3:0]    filt_bypass_o,
  output logic [4:0]    port_ctl_o,
  output logic [5:0]    fladj_o,
  output logic          big_endian_o,
  output logic          coherent_o,
  output logic          bm_enable_o,
  output logic          slv_err_en_o,
  output logic [DW-1:0] spare_o
);
  localparam logic [AW-1:0] OFF_FILT  = AW'('h30);
  localparam logic [AW-1:0] OFF_PORT  = AW'('h34);
  localparam logic [AW-1:0] OFF_FLADJ = AW'('h38);
  localparam logic [AW-1:0] OFF_ENDN  = AW'('h40);
  localparam logic [AW-1:0] OFF_COH   = AW'('h44);
  localparam logic [AW-1:0] OFF_BME   = AW'('h48);
  localparam logic [AW-1:0] OFF_SERR  = AW'('h60);
  localparam logic [AW-1:0] OFF_ISTAT = AW'('h64);
  localparam logic [AW-1:0] OFF_IMASK = AW'('h68);
  localparam logic [AW-1:0] OFF_IEN   = AW'('h6C);
  localparam logic [AW-1:0] OFF_IDIS  = AW'('h70);
  localparam logic [AW-1:0] OFF_SPARE = AW'('h78);
  localparam logic [5:0]    FLADJ_RST = 6'h20;

  logic [3:0]    filt_q;
  logic [4:0]    port_q;
  logic [5:0]    fl_q;
  logic          endn_q, coh_q, bme_q, serr_q;
  logic [1:0]    stat_q, mask_q;
  logic [DW-1:0] spare_q;

  logic       wr_stat, wr_en, wr_dis;
  logic [1:0] wbits, evt;

  assign wr_stat = bus_wr && (bus_addr == OFF_ISTAT);
  assign wr_en   = bus_wr && (bus_addr == OFF_IEN);
  assign wr_dis  = bus_wr && (bus_addr == OFF_IDIS);
  assign wbits   = bus_wdata[1:0];
  assign evt     = {err_host_sys, err_addr_dec};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q  <= '0;
      port_q  <= '0;
      fl_q    <= FLADJ_RST;
      endn_q  <= 1'b0;
      coh_q   <= 1'b0;
      bme_q   <= 1'b1;
      serr_q  <= 1'b0;
      spare_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_FILT:  filt_q  <= bus_wdata[3:0];
        OFF_PORT:  port_q  <= bus_wdata[4:0];
        OFF_FLADJ: fl_q    <= bus_wdata[5:0];
        OFF_ENDN:  endn_q  <= bus_wdata[0];
        OFF_COH:   coh_q   <= bus_wdata[0];
        OFF_BME:   bme_q   <= bus_wdata[0];
        OFF_SERR:  serr_q  <= bus_wdata[0];
        OFF_SPARE: spare_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 2'b00;
      mask_q <= 2'b11;
    end else begin
      stat_q <= (stat_q & ~(wr_stat ? wbits : 2'b00)) | evt;
      if (wr_en)       mask_q <= mask_q & ~wbits;
      else if (wr_dis) mask_q <= mask_q | wbits;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_FILT:  bus_rdata = DW'(filt_q);
      OFF_PORT:  bus_rdata = DW'(port_q);
      OFF_FLADJ: bus_rdata = DW'(fl_q);
      OFF_ENDN:  bus_rdata = DW'(endn_q);
      OFF_COH:   bus_rdata = DW'(coh_q);
      OFF_BME:   bus_rdata = DW'(bme_q);
      OFF_SERR:  bus_rdata = DW'(serr_q);
      OFF_ISTAT: bus_rdata = DW'(stat_q);
      OFF_IMASK: bus_rdata = DW'(mask_q);
      OFF_SPARE: bus_rdata = spare_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_out       = |(stat_q & ~mask_q);
  assign filt_bypass_o = filt_q;
  assign port_ctl_o    = port_q;
  assign fladj_o       = fl_q;
  assign big_endian_o  = endn_q;
  assign coherent_o    = coh_q;
  assign bm_enable_o   = bme_q;
  assign slv_err_en_o  = serr_q;
  assign spare_o       = spare_q;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_FILT) |-> (bus_rdata[DW-1:4] == '0));
  assert_wo_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_IEN || bus_addr == OFF_IDIS) |-> (bus_rdata == '0));
  assert_mask_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_IMASK) |=> $stable(mask_q));
  assert_enable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mask_q & $past(bus_wdata[1:0])) == 2'b00));
  assert_disable_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((mask_q & $past(bus_wdata[1:0])) == $past(bus_wdata[1:0])));
  assert_host_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_host_sys |=> stat_q[1]);
  assert_dec_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_addr_dec |=> stat_q[0]);
  assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(err_host_sys || err_addr_dec || wr_en));
endmodule

// File: tb/usb_ctl_csr_tb_top.sv
`timescale 1ns/1ps
module usb_ctl_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        err_host_sys = 1'b0, err_addr_dec = 1'b0;
  logic        irq_out;
  logic [3:0]  filt_bypass_o;
  logic [4:0]  port_ctl_o;
  logic [5:0]  fladj_o;
  logic        big_endian_o, coherent_o, bm_enable_o, slv_err_en_o;
  logic [31:0] spare_o;

  int checks = 0, fails = 0;
  bit done = 0;

  usb_ctl_csr dut_i (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input logic [1:0] s);
    @(negedge clk); err_host_sys = s[1]; err_addr_dec = s[0];
    @(negedge clk); err_host_sys = 1'b0; err_addr_dec = 1'b0;
  endtask

  function automatic bit mapped(input int a);
    case (a)
      'h30, 'h34, 'h38, 'h40, 'h44, 'h48, 'h60, 'h64, 'h68, 'h6C, 'h70, 'h78: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] fmask(input int a);
    case (a)
      'h30: return 32'hF;
      'h34: return 32'h1F;
      'h38: return 32'h3F;
      'h78: return 32'hFFFF_FFFF;
      default: return 32'h1;
    endcase
  endfunction

  function automatic logic [31:0] port_of(input int a);
    case (a)
      'h30: return {28'd0, filt_bypass_o};
      'h34: return {27'd0, port_ctl_o};
      'h38: return {26'd0, fladj_o};
      'h40: return {31'd0, big_endian_o};
      'h44: return {31'd0, coherent_o};
      'h48: return {31'd0, bm_enable_o};
      'h60: return {31'd0, slv_err_en_o};
      default: return spare_o;
    endcase
  endfunction

  int ctl_addrs [9] = '{'h30, 'h34, 'h38, 'h40, 'h44, 'h48, 'h60, 'h78, 'h78};
  logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0};

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] snap [9];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 128; a += 4) begin
      if (mapped(a)) begin
        rd(7'(a), r);
        chk("R1 reset value", r, (a == 'h38) ? 32'h20 : (a == 'h48) ? 32'h1 :
                                  (a == 'h68) ? 32'h3 : 32'h0);
      end
    end
    chk("R1 irq after reset", {31'd0, irq_out}, 32'h0);

    // R2 / R3 field masking and output ports
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 4; p++) begin
        wr(7'(ctl_addrs[i]), pats[p]);
        rd(7'(ctl_addrs[i]), r);
        if (ctl_addrs[i] == 'h78) begin
          chk("R3 spare readback", r, pats[p]);
          chk("R3 spare port", port_of(ctl_addrs[i]), pats[p]);
        end else begin
          chk("R2 field readback", r, pats[p] & fmask(ctl_addrs[i]));
          chk("R2 port value", port_of(ctl_addrs[i]), pats[p] & fmask(ctl_addrs[i]));
        end
      end
    end

    // R4 unmapped sweep: known nonzero state first
    for (int i = 0; i < 8; i++) wr(7'(ctl_addrs[i]), 32'h0);
    wr(7'h78, 32'h1234_5678);
    wr(7'h6C, 32'h3);
    pulse(2'b11);
    for (int i = 0; i < 8; i++) snap[i] = port_of(ctl_addrs[i]);
    for (int a = 0; a < 128; a++) begin
      if (!mapped(a)) begin
        wr(7'(a), 32'hFFFF_FFFF);
        rd(7'(a), r);
        chk("R4 unmapped read zero", r, 32'h0);
        for (int i = 0; i < 8; i++) chk("R4 ports unchanged", port_of(ctl_addrs[i]), snap[i]);
        rd(7'h64, r); chk("R4 status unchanged", r, 32'h3);
        rd(7'h68, r); chk("R4 mask unchanged", r, 32'h0);
      end
    end

    // R5 write-one-to-clear per bit
    wr(7'h64, 32'h1);
    rd(7'h64, r); chk("R5 clear bit0 only", r, 32'h2);
    wr(7'h64, 32'h0);
    rd(7'h64, r); chk("R5 write zero keeps", r, 32'h2);
    wr(7'h64, 32'h2);
    rd(7'h64, r); chk("R5 clear bit1", r, 32'h0);

    // R6 set wins against same-cycle clear
    @(negedge clk); bus_wr = 1'b1; bus_addr = 7'h64; bus_wdata = 32'h0; err_addr_dec = 1'b1;
    @(negedge clk); bus_wr = 1'b0; err_addr_dec = 1'b0;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 7'h64; bus_wdata = 32'h3; err_host_sys = 1'b1;
    @(negedge clk); bus_wr = 1'b0; err_host_sys = 1'b0;
    rd(7'h64, r); chk("R6 set beats clear", r, 32'h2);
    wr(7'h64, 32'h3);

    // R7 mask ignores direct writes
    wr(7'h70, 32'h3);
    wr(7'h68, 32'h0);
    rd(7'h68, r); chk("R7 mask write ignored", r, 32'h3);
    wr(7'h6C, 32'h2);
    wr(7'h68, 32'h3);
    rd(7'h68, r); chk("R7 mask write ignored 2", r, 32'h1);

    // R8 / R9 sweep of status pattern x enable pattern
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        wr(7'h70, 32'h3);
        wr(7'h64, 32'h3);
        @(negedge clk); err_host_sys = s[1]; err_addr_dec = s[0]; #1;
        chk("R8 irq not before edge", {31'd0, irq_out}, 32'h0);
        @(negedge clk); err_host_sys = 1'b0; err_addr_dec = 1'b0;
        rd(7'h64, r); chk("R9 status bit mapping", r, 32'(s));
        chk("R8 irq masked", {31'd0, irq_out}, 32'h0);
        wr(7'h6C, 32'(e) | 32'hFFFF_FFFC);
        rd(7'h68, r); chk("R7 enable clears mask", r, 32'(3 & ~e));
        rd(7'h6C, r); chk("R7 enable reads zero", r, 32'h0);
        rd(7'h70, r); chk("R7 disable reads zero", r, 32'h0);
        chk("R8 irq level", {31'd0, irq_out}, 32'((s & e) != 0));
        wr(7'h70, 32'(e));
        rd(7'h68, r); chk("R7 disable sets mask", r, 32'h3);
        chk("R8 irq after disable", {31'd0, irq_out}, 32'h0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule